// File: doc/BRIEF.md
# Cumulative Row Boundary Address Decoder

This block turns a physical memory address into the index of the DRAM chip-select row that holds it. Software loads a bank of row limit registers. Each limit is a running total of installed memory in 64 MiB units, so row i covers the space from the limit of row i-1 up to its own limit. A row whose limit repeats the previous one is empty and is never chosen.

A mode register sets single-channel operation, where eight rows take part, or dual-channel operation, where only the first four do. A per-row 3-bit attribute gives the page size of each row. The decoder compares the top seven address bits against every active row range in parallel. It picks the lowest row that matches and registers the row index, a hit flag and that row's attribute.

Top module: `row_boundary_decoder`

## Requirements
- R1: While reset is held, and on the first decode after it, the outputs are hit_o=0, row_o=0 and attr_o=0. All limits reset to zero, so every address misses until limits are written.
- R2: A write to wr_addr 0..7 loads the limit of row wr_addr from wr_data[6:0]. wr_data[7] and all higher data bits are ignored.
- R3: The address unit is addr_i[32:26]. Row i is selected when that unit is at least the limit of row i-1 (zero for row 0) and below the limit of row i.
- R4: A row whose limit equals the limit of the row before it is never selected. An address in the next non-empty range selects that later row.
- R5: With ascending limits, an address whose unit is at or above the limit of the last active row gives hit_o=0.
- R6: wr_addr 12 writes the mode register, and wr_data[22:21]=01 selects dual-channel mode. In dual-channel mode only rows 0..3 take part, so the limit of row 3 is the top of memory. Every other value of bits 22:21 selects single-channel mode with all eight rows.
- R7: wr_addr 8+k holds the attributes of row 2k in wr_data[2:0] and of row 2k+1 in wr_data[6:4]. On a hit, attr_o is the code of the selected row: 000=4 KiB, 001=8 KiB, 010=16 KiB, 011=32 KiB.
- R8: The result for an address appears after exactly one rising clock edge. It does not change between edges even if addr_i does.
- R9: When ranges overlap because limits are written out of order, the lowest-numbered matching row is reported.
- R10: On a miss, row_o and attr_o are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select: 0..7 limits, 8..11 attributes, 12 mode |
| wr_data | input | 32 | Register write data |
| addr_i | input | 33 | Physical address to decode |
| row_o | output | 3 | Selected row index |
| hit_o | output | 1 | Address falls in a populated active row |
| attr_o | output | 3 | Page-size code of the selected row |

## Verification
If a stored limit is corrupted, the ports show it as a row index or hit flag that is wrong one edge after an address near that limit is presented. The bench therefore probes just below, at and just above each limit. A stale mode bit shows up as hits on rows 4..7 or as misses above row 3's limit, on the first decode after the mode write. A broken priority chain or attribute lane shows up at once as a wrong row_o or attr_o on overlapping or adjacent ranges.

// File: rtl/rdec_pkg.sv
// Package: shared defaults and helpers for the row boundary decoder.
// Assumes callers size their ports from these defaults or override them consistently.
package rdec_pkg;
    localparam int DEF_ROWS     = 8;
    localparam int DEF_BND_W    = 7;
    localparam int DEF_ATTR_W   = 3;
    localparam int DEF_ADDR_W   = 33;
    localparam int DEF_GRAIN    = 26;
    localparam int DEF_REG_AW   = 4;
    localparam int DEF_DATA_W   = 32;
    localparam int DEF_CHAN_LSB = 21;

    // Channel field encoding of the mode register.
    typedef enum logic [1:0] {
        CHAN_ONE = 2'b00,
        CHAN_TWO = 2'b01
    } chan_code_e;

    // Returns 1 when the channel field requests dual-channel operation.
    function automatic logic chan_is_dual(input logic [1:0] code);
        return code == CHAN_TWO;
    endfunction
endpackage

// File: rtl/rdec_regs.sv
// Module: register bank holding row limits, packed row attributes and channel mode.
// Assumes: limits at wr_addr 0..ROWS-1, attribute bytes at ROWS..ROWS+ROWS/2-1
// (two rows per byte, 4-bit lanes), mode register at ROWS+ROWS/2. Write only.
module rdec_regs
    import rdec_pkg::*;
#(
    parameter int ROWS     = DEF_ROWS,
    parameter int BND_W    = DEF_BND_W,
    parameter int ATTR_W   = DEF_ATTR_W,
    parameter int REG_AW   = DEF_REG_AW,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int CHAN_LSB = DEF_CHAN_LSB
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [REG_AW-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [ROWS*BND_W-1:0]   bnd_flat,
    output logic [ROWS*ATTR_W-1:0]  attr_flat,
    output logic                    dual_mode
);
    localparam int ATTR_BASE = ROWS;
    localparam int MODE_ADDR = ROWS + ROWS / 2;
    localparam int LANE_W    = 4;

    logic unused_data;
    // Collects data bits no register stores.
    assign unused_data = ^{wr_data[DATA_W-1:CHAN_LSB+2], wr_data[CHAN_LSB-1:8], wr_data[7], wr_data[3]};

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            localparam int ABYTE = ATTR_BASE + r / 2;
            localparam int ALANE = (r % 2) * LANE_W;
            logic [BND_W-1:0]  bnd_q;
            logic [ATTR_W-1:0] attr_q;

            // Loads this row's limit from the low data bits.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bnd_q <= '0;
                end else if (wr_en && wr_addr == REG_AW'(r)) begin
                    bnd_q <= wr_data[BND_W-1:0];
                end
            end

            // Loads this row's attribute from its lane of the shared byte.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    attr_q <= '0;
                end else if (wr_en && wr_addr == REG_AW'(ABYTE)) begin
                    attr_q <= wr_data[ALANE +: ATTR_W];
                end
            end

            assign bnd_flat[r*BND_W +: BND_W]    = bnd_q;
            assign attr_flat[r*ATTR_W +: ATTR_W] = attr_q;
        end
    endgenerate

    // Keeps the channel mode decoded from the mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dual_mode <= 1'b0;
        end else if (wr_en && wr_addr == REG_AW'(MODE_ADDR)) begin
            dual_mode <= chan_is_dual(wr_data[CHAN_LSB +: 2]);
        end
    end
endmodule

// File: rtl/rdec_cmp.sv
// Module: parallel range comparators, one per row.
// Assumes: row r spans [limit r-1, limit r), row 0 starts at zero; rows at or
// beyond the active count are masked out. Purely combinational.
module rdec_cmp #(
    parameter int ROWS  = 8,
    parameter int BND_W = 7,
    parameter int CMP_W = 7
) (
    input  logic [CMP_W-1:0]      unit_i,
    input  logic [ROWS*BND_W-1:0] bnd_flat,
    input  logic                  dual_mode,
    output logic [ROWS-1:0]       match_o
);
    localparam int HALF = ROWS / 2;

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_cmp
            logic [CMP_W-1:0] upper;
            logic [CMP_W-1:0] lower;
            logic             active;

            assign upper = CMP_W'(bnd_flat[r*BND_W +: BND_W]);
            if (r == 0) begin : g_first
                assign lower = '0;
            end else begin : g_rest
                assign lower = CMP_W'(bnd_flat[(r-1)*BND_W +: BND_W]);
            end
            if (r < HALF) begin : g_low
                assign active = 1'b1;
            end else begin : g_high
                assign active = !dual_mode;
            end

            // Flags an address unit inside this row's half-open range.
            always_comb begin
                match_o[r] = active && (unit_i >= lower) && (unit_i < upper);
            end
        end
    endgenerate
endmodule

// File: rtl/rdec_prio.sv
// Module: lowest-index priority pick with attribute select.
// Assumes any number of match bits may be set; returns zeros when none is.
module rdec_prio #(
    parameter int ROWS   = 8,
    parameter int ATTR_W = 3,
    parameter int ROW_W  = 3
) (
    input  logic [ROWS-1:0]        match_i,
    input  logic [ROWS*ATTR_W-1:0] attr_flat,
    output logic                   any_o,
    output logic [ROW_W-1:0]       row_o,
    output logic [ATTR_W-1:0]      attr_o
);
    // Scans from the top so the lowest set bit is the last to win.
    always_comb begin
        row_o = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (match_i[r]) row_o = ROW_W'(r);
        end
    end

    // Reports whether any row matched.
    always_comb begin
        any_o = |match_i;
    end

    // Picks the chosen row's attribute, zero on a miss.
    always_comb begin
        attr_o = any_o ? attr_flat[row_o*ATTR_W +: ATTR_W] : '0;
    end
endmodule

// File: rtl/row_boundary_decoder.sv
// Module: top of the cumulative row boundary decoder.
// Takes the address unit above GRAIN, compares it against all active row ranges,
// keeps the lowest match and registers row, hit and attribute (one-cycle latency).
module row_boundary_decoder
    import rdec_pkg::*;
#(
    parameter int ROWS     = DEF_ROWS,
    parameter int BND_W    = DEF_BND_W,
    parameter int ATTR_W   = DEF_ATTR_W,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int GRAIN    = DEF_GRAIN,
    parameter int REG_AW   = DEF_REG_AW,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int CHAN_LSB = DEF_CHAN_LSB,
    localparam int ROW_W   = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ROW_W-1:0]  row_o,
    output logic              hit_o,
    output logic [ATTR_W-1:0] attr_o
);
    localparam int UNIT_W = ADDR_W - GRAIN;
    localparam int CMP_W  = (UNIT_W > BND_W) ? UNIT_W : BND_W;

    logic [ROWS*BND_W-1:0]  bnd_flat;
    logic [ROWS*ATTR_W-1:0] attr_flat;
    logic                   dual_mode;
    logic [CMP_W-1:0]       unit_w;
    logic [ROWS-1:0]        match_w;
    logic                   any_w;
    logic [ROW_W-1:0]       row_w;
    logic [ATTR_W-1:0]      attr_w;
    logic [GRAIN-1:0]       unused_low;

    // Takes the coarse address unit; bits below the grain do not matter.
    assign unit_w     = CMP_W'(addr_i[ADDR_W-1:GRAIN]);
    assign unused_low = addr_i[GRAIN-1:0];

    rdec_regs #(
        .ROWS(ROWS), .BND_W(BND_W), .ATTR_W(ATTR_W),
        .REG_AW(REG_AW), .DATA_W(DATA_W), .CHAN_LSB(CHAN_LSB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .bnd_flat(bnd_flat), .attr_flat(attr_flat),
        .dual_mode(dual_mode)
    );

    rdec_cmp #(.ROWS(ROWS), .BND_W(BND_W), .CMP_W(CMP_W)) u_cmp (
        .unit_i(unit_w), .bnd_flat(bnd_flat), .dual_mode(dual_mode),
        .match_o(match_w)
    );

    rdec_prio #(.ROWS(ROWS), .ATTR_W(ATTR_W), .ROW_W(ROW_W)) u_prio (
        .match_i(match_w), .attr_flat(attr_flat), .any_o(any_w),
        .row_o(row_w), .attr_o(attr_w)
    );

    // Registers the decode result one edge after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_o  <= '0;
            hit_o  <= 1'b0;
            attr_o <= '0;
        end else begin
            row_o  <= row_w;
            hit_o  <= any_w;
            attr_o <= attr_w;
        end
    end
endmodule

// File: rtl/rdec_chk.sv
// Checker: temporal properties of the row boundary decoder, bound to the top.
module rdec_chk #(
    parameter int ROWS   = 8,
    parameter int BND_W  = 7,
    parameter int ATTR_W = 3,
    parameter int CMP_W  = 7,
    parameter int ROW_W  = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [CMP_W-1:0]      unit_w,
    input logic [ROWS*BND_W-1:0] bnd_flat,
    input logic                  dual_mode,
    input logic [ROW_W-1:0]      row_o,
    input logic                  hit_o,
    input logic [ATTR_W-1:0]     attr_o
);
    logic [CMP_W-1:0] unit_d;
    logic [BND_W-1:0] bnd_d [ROWS];
    logic             dual_d;
    logic [CMP_W-1:0] upper_w;
    logic [CMP_W-1:0] lower_w;

    // Holds the inputs the output register saw at the last edge.
    always_ff @(posedge clk) begin
        unit_d <= unit_w;
        dual_d <= dual_mode;
        for (int r = 0; r < ROWS; r++) bnd_d[r] <= bnd_flat[r*BND_W +: BND_W];
    end

    // Looks up the range of the reported row.
    always_comb begin
        upper_w = CMP_W'(bnd_d[row_o]);
        lower_w = (row_o == '0) ? '0 : CMP_W'(bnd_d[row_o - 1'b1]);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (!hit_o && row_o == '0 && attr_o == '0));
    // R3
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (unit_d >= lower_w && unit_d < upper_w));
    // R4
    nonempty_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (upper_w != lower_w));
    // R6
    dual_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && dual_d) |-> (int'(row_o) < ROWS / 2));
    // R10
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (row_o == '0 && attr_o == '0));
endmodule

bind row_boundary_decoder rdec_chk #(
    .ROWS(ROWS), .BND_W(BND_W), .ATTR_W(ATTR_W), .CMP_W(CMP_W), .ROW_W(ROW_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .unit_w(unit_w), .bnd_flat(bnd_flat),
    .dual_mode(dual_mode), .row_o(row_o), .hit_o(hit_o), .attr_o(attr_o)
);

// File: tb/row_boundary_decoder_tb.sv
// Directed bench for the row boundary decoder; each task checks its own results.
module row_boundary_decoder_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [32:0] addr_i = '0;
    logic [2:0]  row_o;
    logic        hit_o;
    logic [2:0]  attr_o;

    int n_chk = 0;
    int n_bad = 0;

    row_boundary_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .addr_i(addr_i), .row_o(row_o), .hit_o(hit_o),
        .attr_o(attr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [32:0] at_unit(input int unit, input logic [25:0] off);
        return {unit[6:0], off};
    endfunction

    task automatic check(input string req, input logic h, input int r, input int a);
        n_chk++;
        if (hit_o !== h || row_o !== r[2:0] || attr_o !== a[2:0]) begin
            n_bad++;
            $display("FAIL %s: got hit=%0d row=%0d attr=%0d, expected hit=%0d row=%0d attr=%0d",
                     req, hit_o, row_o, attr_o, h, r, a);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic probe(input string req, input int unit, input logic [25:0] off,
                         input logic h, input int r, input int a);
        @(negedge clk);
        addr_i = at_unit(unit, off);
        @(negedge clk);
        check(req, h, r, a);
    endtask

    task automatic load_limits(input int b0, input int b1, input int b2, input int b3,
                               input int b4, input int b5, input int b6, input int b7);
        wr(0, b0); wr(1, b1); wr(2, b2); wr(3, b3);
        wr(4, b4); wr(5, b5); wr(6, b6); wr(7, b7);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 in reset", 1'b0, 0, 0);
        rst_n = 1'b1;
        probe("R1 after reset", 0, 26'h0, 1'b0, 0, 0);
        probe("R1 after reset high", 3, 26'h123, 1'b0, 0, 0);
    endtask

    task automatic t_single;
        load_limits(2, 2, 5, 5, 5, 8, 8, 10);
        wr(8, 32'h01); wr(9, 32'h02); wr(10, 32'h30); wr(11, 32'h10);
        probe("R3 R7 row0 base", 0, 26'h0, 1'b1, 0, 1);
        probe("R3 row0 top", 1, 26'h3FFFFFF, 1'b1, 0, 1);
        probe("R4 skip empty row1", 2, 26'h0, 1'b1, 2, 2);
        probe("R3 row2 top", 4, 26'h3FFFFFF, 1'b1, 2, 2);
        probe("R4 skip rows3,4", 5, 26'h0, 1'b1, 5, 3);
        probe("R4 skip row6", 8, 26'h0, 1'b1, 7, 1);
        probe("R3 row7 top", 9, 26'h3FFFFFF, 1'b1, 7, 1);
        probe("R5 R10 at total", 10, 26'h0, 1'b0, 0, 0);
        probe("R5 far above", 127, 26'h3FFFFFF, 1'b0, 0, 0);
    endtask

    task automatic t_reserved_bit;
        wr(7, 32'hFFFF_FF8A);
        probe("R2 bit7 ignored miss", 10, 26'h0, 1'b0, 0, 0);
        probe("R2 bit7 ignored hit", 9, 26'h0, 1'b1, 7, 1);
        wr(7, 32'h0000_00FF);
        probe("R2 limit 127", 100, 26'h0, 1'b1, 7, 1);
        wr(7, 32'h0000_000A);
    endtask

    task automatic t_dual;
        wr(12, 32'h0020_0000);
        probe("R6 dual top is row3", 5, 26'h0, 1'b0, 0, 0);
        probe("R6 dual row2", 4, 26'h0, 1'b1, 2, 2);
        probe("R6 dual upper rows off", 8, 26'h0, 1'b0, 0, 0);
        wr(12, 32'h0040_0000);
        probe("R6 code10 single", 8, 26'h0, 1'b1, 7, 1);
        wr(12, 32'h0020_0000);
        wr(12, 32'h000C_0003);
        probe("R6 code00 single", 5, 26'h0, 1'b1, 5, 3);
    endtask

    task automatic t_latency;
        @(negedge clk);
        addr_i = at_unit(8, 26'h0);
        @(posedge clk);
        #1 check("R8 one edge", 1'b1, 7, 1);
        addr_i = at_unit(2, 26'h0);
        #2 check("R8 holds between edges", 1'b1, 7, 1);
        @(posedge clk);
        #1 check("R8 next edge", 1'b1, 2, 2);
    endtask

    task automatic t_overlap;
        load_limits(4, 2, 6, 6, 6, 6, 6, 6);
        probe("R9 lowest wins", 3, 26'h0, 1'b1, 0, 1);
        probe("R9 row0 low", 1, 26'h0, 1'b1, 0, 1);
        probe("R9 inverted row1 empty", 4, 26'h0, 1'b1, 2, 2);
        probe("R9 above all", 6, 26'h0, 1'b0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got running, expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_single();
        t_reserved_bit();
        t_dual();
        t_latency();
        t_overlap();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule